// File: doc/BRIEF.md
# Programmable Chip Select Unit

This block compares the address of each bus transfer with a set of programmable address windows. When a window matches, it drives the active-low select line for that window. Each window holds a base address, an address mask, a port size, a burst-capable flag, a wait-state count and a termination mode. A small register write port loads these settings. The selected window's port size and burst flag are presented on the outputs for as long as the transfer lasts.

A transfer can end in one of two ways. With internal termination, a wait-state counter produces a one-cycle transfer acknowledge. With external termination, the select stays asserted until an external acknowledge input arrives.

Select 0 is the boot select. After reset it matches every address, and it takes its port size and termination mode from three strap inputs latched while reset is held. Once its own window is programmed and marked valid, it matches only that window. Select 1 can also be enabled to respond to CPU-space cycles, such as interrupt acknowledge, whatever the address.

Top module: `cs_unit`

## Requirements
- R1: All select outputs `cs_n_o` are active low. All of them are high after reset and whenever no transfer is in progress.
- R2: A window matches when `((addr ^ base) & ~mask) == 0`. A mask bit of 1 excludes that address bit from the compare.
- R3: While bit 8 (valid) of select 0's control word is clear, select 0 matches every non-CPU-space address. In that mode it uses the latched straps: port size = `strap_i[1:0]`, termination internal when `strap_i[2]` = 1, wait count `BOOT_WS`, and burst off.
- R4: Once select 0's valid bit is set, select 0 matches only its programmed window.
- R5: Selects 1 and higher never assert after reset until bit 8 (valid) of their control word is set.
- R6: When several windows match, only the lowest-numbered one asserts. At most one select is low at any time.
- R7: Control bit 7 = 1 selects internal termination, with the wait count in bits 3:0. For a transfer started with wait count N, the select is low for N+1 cycles. `ack_o` is high for exactly one cycle, the last of those cycles.
- R8: Control bit 7 = 0 selects external termination. The select stays low and `ack_o` stays low until `ext_ack_i` is sampled high; the select is released on the next cycle.
- R9: While a select is low, `port_size_o` carries control bits 5:4 and `burst_o` carries control bit 6 of the chosen window. Both outputs are zero when no select is low.
- R10: When `xfer_cpu_i` = 1, only select 1 can assert, and it does so whatever the address, provided its control bit 9 is set. Otherwise no select asserts.
- R11: A `xfer_start_i` that arrives while a transfer is in progress is ignored.
- R12: Configuration writes use `cfg_field_i` to pick the word being written: 0 = base, 1 = mask, 2 = control. `cfg_sel_i` picks the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 3 | Boot straps, latched while reset is held |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | $clog2(NUM_CS) | Window index for the write |
| cfg_field_i | input | 2 | Word select: base, mask or control |
| cfg_wdata_i | input | ADDR_W | Write data |
| xfer_start_i | input | 1 | Transfer start pulse |
| xfer_addr_i | input | ADDR_W | Transfer address |
| xfer_cpu_i | input | 1 | Transfer is a CPU-space cycle |
| ext_ack_i | input | 1 | External transfer acknowledge |
| cs_n_o | output | NUM_CS | Active-low select lines |
| port_size_o | output | 2 | Port size of the active window |
| burst_o | output | 1 | Burst-capable flag of the active window |
| ack_o | output | 1 | Internally generated acknowledge |

## Verification
The directed cases cover four situations: the boot select catching every address, a programmed window that overlaps the boot window and loses to it on priority, windows with their valid bit still clear, and CPU-space cycles with select 1's enable bit both clear and set. Together these separate three things: the mask compare, the priority order, and the enable gating. External transfers use several acknowledge delays, and internal transfers use wait counts from 0 upward, so a wrong counter load or a wrong release cycle shows up as a mismatch on a specific cycle. A start pulse placed in the middle of an external transfer shows whether the transfer in progress is protected. Random addresses drawn near each window's edges, with CPU-space cycles mixed in, are then compared cycle by cycle against a model held in the bench.

// File: rtl/cs_pkg.sv
package cs_pkg;
  parameter int unsigned CS_WS_W = 4;
  localparam int unsigned CTL_PS  = CS_WS_W;
  localparam int unsigned CTL_BST = CS_WS_W + 2;
  localparam int unsigned CTL_INT = CS_WS_W + 3;
  localparam int unsigned CTL_VLD = CS_WS_W + 4;
  localparam int unsigned CTL_CPU = CS_WS_W + 5;

  typedef enum logic [1:0] {FLD_BASE = 2'd0, FLD_MASK = 2'd1, FLD_CTRL = 2'd2} cfg_field_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_INT = 2'd1, ST_EXT = 2'd2} xfer_st_e;

  typedef struct packed {
    logic [1:0]         psize;
    logic               burst;
    logic               intern;
    logic [CS_WS_W-1:0] ws;
  } cs_attr_t;
endpackage

// File: rtl/cs_regs.sv
module cs_regs
  import cs_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned SEL_W = $clog2(NUM_CS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we_i,
  input  logic [SEL_W-1:0]                 sel_i,
  input  logic [1:0]                       field_i,
  input  logic [ADDR_W-1:0]                wdata_i,
  output logic [NUM_CS-1:0][ADDR_W-1:0]    base_o,
  output logic [NUM_CS-1:0][ADDR_W-1:0]    mask_o,
  output cs_attr_t [NUM_CS-1:0]            attr_o,
  output logic [NUM_CS-1:0]                valid_o,
  output logic [NUM_CS-1:0]                cpu_en_o
);
  cs_attr_t wattr;
  always_comb begin
    wattr.ws     = wdata_i[CS_WS_W-1:0];
    wattr.psize  = wdata_i[CTL_PS+1:CTL_PS];
    wattr.burst  = wdata_i[CTL_BST];
    wattr.intern = wdata_i[CTL_INT];
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_win
    logic hit_sel, wr_base, wr_mask, wr_ctrl;
    assign hit_sel = we_i && (sel_i == SEL_W'(i));
    assign wr_base = hit_sel && (field_i == FLD_BASE);
    assign wr_mask = hit_sel && (field_i == FLD_MASK);
    assign wr_ctrl = hit_sel && (field_i == FLD_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_o[i]   <= '0;
        mask_o[i]   <= '0;
        attr_o[i]   <= '0;
        valid_o[i]  <= 1'b0;
        cpu_en_o[i] <= 1'b0;
      end else begin
        if (wr_base) base_o[i] <= wdata_i;
        if (wr_mask) mask_o[i] <= wdata_i;
        if (wr_ctrl) begin
          attr_o[i]   <= wattr;
          valid_o[i]  <= wdata_i[CTL_VLD];
          cpu_en_o[i] <= wdata_i[CTL_CPU];
        end
      end
    end
  end
endmodule

// File: rtl/cs_match.sv
module cs_match
  import cs_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned ADDR_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          cpu_i,
  input  logic [NUM_CS-1:0][ADDR_W-1:0] base_i,
  input  logic [NUM_CS-1:0][ADDR_W-1:0] mask_i,
  input  cs_attr_t [NUM_CS-1:0]         attr_i,
  input  logic [NUM_CS-1:0]             valid_i,
  input  logic [NUM_CS-1:0]             cpu_en_i,
  input  cs_attr_t                      boot_attr_i,
  output logic                          hit_o,
  output logic [NUM_CS-1:0]             sel_oh_o,
  output cs_attr_t                      attr_o
);
  logic [NUM_CS-1:0] raw;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cmp
    logic win;
    assign win = (((addr_i ^ base_i[i]) & ~mask_i[i]) == '0);
    if (i == 0) begin : g_boot
      assign raw[i] = !cpu_i && (!valid_i[i] || win);
    end else if (i == 1) begin : g_cpu
      assign raw[i] = cpu_i ? cpu_en_i[i] : (valid_i[i] && win);
    end else begin : g_std
      assign raw[i] = !cpu_i && valid_i[i] && win;
    end
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    sel_oh_o = '0;
    attr_o   = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (raw[i] && !found) begin
        found       = 1'b1;
        sel_oh_o[i] = 1'b1;
        attr_o      = (i == 0 && !valid_i[0]) ? boot_attr_i : attr_i[i];
      end
    end
    hit_o = found;
  end

  AST_CPU_ONLY_SEL1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_i && hit_o) |-> (sel_oh_o == NUM_CS'(2))); // R10
  AST_BOOT_CATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_i && !valid_i[0]) |-> sel_oh_o[0]); // R3
endmodule

// File: rtl/cs_timer.sv
module cs_timer
  import cs_pkg::*;
#(
  parameter int unsigned NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              hit_i,
  input  logic [NUM_CS-1:0] sel_oh_i,
  input  cs_attr_t          attr_i,
  input  logic              ext_ack_i,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic [1:0]        psize_o,
  output logic              burst_o,
  output logic              ack_o
);
  xfer_st_e           st_q, st_d;
  logic [CS_WS_W-1:0] cnt_q, cnt_d;
  logic [NUM_CS-1:0]  sel_q, sel_d;
  cs_attr_t           attr_q, attr_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sel_d  = sel_q;
    attr_d = attr_q;
    unique case (st_q)
      ST_IDLE: if (start_i && hit_i) begin
        sel_d  = sel_oh_i;
        attr_d = attr_i;
        cnt_d  = attr_i.ws;
        st_d   = attr_i.intern ? ST_INT : ST_EXT;
      end
      ST_INT: if (cnt_q == '0) begin
        st_d   = ST_IDLE;
        sel_d  = '0;
        attr_d = '0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      ST_EXT: if (ext_ack_i) begin
        st_d   = ST_IDLE;
        sel_d  = '0;
        attr_d = '0;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sel_q  <= '0;
      attr_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sel_q  <= sel_d;
      attr_q <= attr_d;
    end
  end

  assign cs_n_o  = ~sel_q;
  assign psize_o = attr_q.psize;
  assign burst_o = attr_q.burst;
  assign ack_o   = (st_q == ST_INT) && (cnt_q == '0);

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o); // R7
  AST_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_q)); // R6
  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EXT && !ext_ack_i) |=> (st_q == ST_EXT && $stable(sel_q) && !ack_o)); // R8
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> ($stable(sel_q) || sel_q == '0)); // R11
endmodule

// File: rtl/cs_unit.sv
module cs_unit
  import cs_pkg::*;
#(
  parameter int unsigned NUM_CS  = 4,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned BOOT_WS = 3,
  localparam int unsigned SEL_W  = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        strap_i,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [1:0]        cfg_field_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic              xfer_start_i,
  input  logic [ADDR_W-1:0] xfer_addr_i,
  input  logic              xfer_cpu_i,
  input  logic              ext_ack_i,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic [1:0]        port_size_o,
  output logic              burst_o,
  output logic              ack_o
);
  logic [1:0] rst_sync_q;
  logic       rst_in_n;
  logic [2:0] strap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_in_n = rst_sync_q[1];

  always_ff @(posedge clk) begin
    if (!rst_in_n) strap_q <= strap_i;
  end

  cs_attr_t boot_attr;
  always_comb begin
    boot_attr.psize  = strap_q[1:0];
    boot_attr.intern = strap_q[2];
    boot_attr.burst  = 1'b0;
    boot_attr.ws     = CS_WS_W'(BOOT_WS);
  end

  logic [NUM_CS-1:0][ADDR_W-1:0] base, mask;
  cs_attr_t [NUM_CS-1:0]         attr;
  logic [NUM_CS-1:0]             valid, cpu_en, sel_oh;
  logic                          hit;
  cs_attr_t                      hit_attr;

  cs_regs #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_in_n), .we_i(cfg_we_i), .sel_i(cfg_sel_i),
    .field_i(cfg_field_i), .wdata_i(cfg_wdata_i), .base_o(base), .mask_o(mask),
    .attr_o(attr), .valid_o(valid), .cpu_en_o(cpu_en)
  );

  cs_match #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_match (
    .clk(clk), .rst_n(rst_in_n), .addr_i(xfer_addr_i), .cpu_i(xfer_cpu_i),
    .base_i(base), .mask_i(mask), .attr_i(attr), .valid_i(valid),
    .cpu_en_i(cpu_en), .boot_attr_i(boot_attr), .hit_o(hit),
    .sel_oh_o(sel_oh), .attr_o(hit_attr)
  );

  cs_timer #(.NUM_CS(NUM_CS)) u_timer (
    .clk(clk), .rst_n(rst_in_n), .start_i(xfer_start_i), .hit_i(hit),
    .sel_oh_i(sel_oh), .attr_i(hit_attr), .ext_ack_i(ext_ack_i),
    .cs_n_o(cs_n_o), .psize_o(port_size_o), .burst_o(burst_o), .ack_o(ack_o)
  );

  AST_IDLE_ATTR: assert property (@(posedge clk) disable iff (!rst_in_n)
    (&cs_n_o) |-> (port_size_o == 2'b00 && !burst_o)); // R9
  AST_ACK_WITH_SEL: assert property (@(posedge clk) disable iff (!rst_in_n)
    ack_o |-> !(&cs_n_o)); // R1
endmodule

// File: tb/cs_unit_tb.sv
module cs_unit_tb;
  localparam int NCS = 4;
  localparam int BWS = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  strap;
  logic        cfg_we;
  logic [1:0]  cfg_sel, cfg_field;
  logic [31:0] cfg_wdata, addr;
  logic        start, cpu, ext_ack;
  logic [3:0]  cs_n;
  logic [1:0]  psize;
  logic        burst, ack;

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] m_base[NCS], m_mask[NCS], m_ctrl[NCS];

  always #10 clk = ~clk;

  cs_unit u_dut (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_field_i(cfg_field), .cfg_wdata_i(cfg_wdata), .xfer_start_i(start),
    .xfer_addr_i(addr), .xfer_cpu_i(cpu), .ext_ack_i(ext_ack), .cs_n_o(cs_n),
    .port_size_o(psize), .burst_o(burst), .ack_o(ack)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(int ws, int ps, bit bst, bit intn, bit vld, bit cpe);
    return {22'd0, cpe, vld, intn, bst, 2'(ps), 4'(ws)};
  endfunction

  function automatic int pick(logic [31:0] a, bit c);
    for (int i = 0; i < NCS; i++) begin
      bit v = m_ctrl[i][8];
      bit w = (((a ^ m_base[i]) & ~m_mask[i]) == 0);
      if (c) begin
        if (i == 1 && m_ctrl[1][9]) return 1;
      end else if (i == 0 && !v) return 0;
      else if (v && w) return i;
    end
    return -1;
  endfunction

  task automatic cfg(int s, int f, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'(s); cfg_field = 2'(f); cfg_wdata = d;
    if (f == 0) m_base[s] = d;
    else if (f == 1) m_mask[s] = d;
    else m_ctrl[s] = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic xfer(logic [31:0] a, bit c, int dly, string req);
    int idx, ws, ps; bit intn, bst;
    idx = pick(a, c);
    if (idx == 0 && !m_ctrl[0][8]) begin
      ws = BWS; ps = strap[1:0]; intn = strap[2]; bst = 0;
    end else if (idx >= 0) begin
      ws = m_ctrl[idx][3:0]; ps = m_ctrl[idx][5:4]; bst = m_ctrl[idx][6]; intn = m_ctrl[idx][7];
    end
    @(negedge clk);
    start = 1; addr = a; cpu = c;
    @(negedge clk);
    start = 0;
    if (idx < 0) begin
      chk(cs_n == 4'hF && !ack, req, {27'd0, ack, cs_n}, 32'h0F);
      return;
    end
    if (intn) begin
      for (int k = 0; k <= ws; k++) begin
        chk(cs_n == ~(4'b1 << idx) && psize == 2'(ps) && burst == bst, req,
            {25'd0, burst, psize, cs_n}, {25'd0, bst, 2'(ps), ~(4'b1 << idx)});
        chk(ack == (k == ws), {req, " R7 ack"}, 32'(ack), 32'(k == ws));
        @(negedge clk);
      end
    end else begin
      for (int k = 0; k <= dly; k++) begin
        chk(cs_n == ~(4'b1 << idx) && psize == 2'(ps) && !ack, {req, " R8"},
            {27'd0, ack, cs_n}, {28'd0, ~(4'b1 << idx)});
        if (k == dly) ext_ack = 1;
        @(negedge clk);
      end
      ext_ack = 0;
    end
    chk(cs_n == 4'hF && psize == 0 && !burst && !ack, {req, " R1 release"},
        {25'd0, ack, psize, cs_n}, 32'h0F);
  endtask

  initial begin
    for (int n = 0; n < 150000; n++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NCS; i++) begin m_base[i] = 0; m_mask[i] = 0; m_ctrl[i] = 0; end
    rst_n = 0; strap = 3'b110; cfg_we = 0; cfg_sel = 0; cfg_field = 0; cfg_wdata = 0;
    start = 0; addr = 0; cpu = 0; ext_ack = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(cs_n == 4'hF && !ack && psize == 0, "R1 reset", {25'd0, ack, psize, cs_n}, 32'h0F);

    // R3: boot select catches everything with strap attributes
    xfer(32'hDEAD_BEE0, 0, 0, "R3 boot any");
    xfer(32'h0000_0004, 0, 0, "R3 boot low");
    xfer(32'h1234_5678, 1, 0, "R10 cpu no enable");

    // R12/R6: sel1 programmed but boot still wins
    cfg(1, 0, 32'h1000_0000);
    cfg(1, 1, 32'h00FF_FFFF);
    cfg(1, 2, mk_ctrl(2, 1, 1, 1, 1, 0));
    xfer(32'h1000_0040, 0, 0, "R6 boot priority");

    // R4: boot window programmed
    cfg(0, 0, 32'h0000_0000);
    cfg(0, 1, 32'h000F_FFFF);
    cfg(0, 2, mk_ctrl(1, 0, 0, 1, 1, 0));
    xfer(32'h1000_0040, 0, 0, "R4 sel1 now");
    xfer(32'h0005_0000, 0, 0, "R4 sel0 window");
    xfer(32'h8000_0000, 0, 0, "R4 no match");
    xfer(32'h0010_0000, 0, 0, "R2 just outside");
    xfer(32'h10FF_FFFF, 0, 0, "R2 mask top");

    // R5: disabled window
    cfg(3, 0, 32'h3000_0000);
    cfg(3, 1, 32'h0000_FFFF);
    cfg(3, 2, mk_ctrl(0, 3, 1, 1, 0, 0));
    xfer(32'h3000_0010, 0, 0, "R5 not valid");
    cfg(3, 2, mk_ctrl(0, 3, 1, 1, 1, 0));
    xfer(32'h3000_0010, 0, 0, "R5 valid ws0");

    // R8: external termination
    cfg(2, 0, 32'h2000_0000);
    cfg(2, 1, 32'h0FFF_FFFF);
    cfg(2, 2, mk_ctrl(5, 2, 0, 0, 1, 0));
    xfer(32'h2000_1234, 0, 0, "R8 ext d0");
    xfer(32'h2ABC_0000, 0, 3, "R8 ext d3");

    // R10: cpu space
    cfg(1, 2, mk_ctrl(2, 1, 1, 1, 1, 1));
    xfer(32'h0005_0000, 1, 0, "R10 cpu sel1");

    // R11: start during active transfer is ignored
    @(negedge clk); start = 1; addr = 32'h2000_0000; cpu = 0;
    @(negedge clk); start = 0;
    @(negedge clk); start = 1; addr = 32'h0000_0100;
    @(negedge clk); start = 0;
    chk(cs_n == 4'b1011, "R11 hold", 32'(cs_n), 32'hB);
    ext_ack = 1;
    @(negedge clk); ext_ack = 0;
    chk(cs_n == 4'hF, "R11 released", 32'(cs_n), 32'hF);
    @(negedge clk);
    chk(cs_n == 4'hF, "R11 no late start", 32'(cs_n), 32'hF);

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      int r = $urandom % 5;
      case (r)
        0: a = $urandom & 32'h001F_FFFF;
        1: a = 32'h1000_0000 | ($urandom & 32'h01FF_FFFF);
        2: a = 32'h2000_0000 | ($urandom & 32'h1FFF_FFFF);
        3: a = 32'h3000_0000 | ($urandom & 32'h0001_FFFF);
        default: a = $urandom;
      endcase
      xfer(a, ($urandom % 8) == 0, $urandom % 4, "R2 R6 R9 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule